// File: doc/BRIEF.md
# CompactFlash Metadata Storage Engine

This block serves the metadata sub-commands of a CompactFlash-style disk. It holds a small byte-wide store, 32 bytes by default. When it sees a command strobe, it runs one of three operations: an inquiry that describes the store, a read that copies store bytes into a 512-byte transfer buffer, or a write that copies buffer bytes back into the store. The strobe arrives with a feature code, a 16-bit sector offset and a sector count. The host side reaches the transfer buffer through a plain 16-bit word port. A one-cycle `done` pulse marks the end of each command and serves as the interrupt.

The engine also keeps a media-changed flag. Other disk commands raise it through `media_mark`, and a successful metadata write clears it. The flag is reported in the inquiry response and at the head of every read response.

Top module: `cf_meta_engine`

## Requirements
- R1: Feature code 0x02 selects inquiry, 0x03 selects read and 0x04 selects write. Any other code aborts the command: status becomes 0x01 (error bit, bit 0) and error becomes 0x04 (abort bit, bit 2).
- R2: An inquiry zeroes all 256 buffer words and then sets word 0 = 0x0001, word 1 = 0x0000, word 2 = media flag (bit 0), words 3/4 = capacity in bytes (low/high 16 bits).
- R3: Inquiry words 5/6 hold the store size in sectors (low/high), computed as ((capacity - 1) >> 9) + 1.
- R4: The byte offset is the sector offset shifted left by 9. A read or write whose byte offset exceeds capacity + 2 aborts as in R1 and leaves the buffer, the store and the media flag unchanged.
- R5: A read zeroes the buffer, puts the media flag in word 0 and copies store bytes from the byte offset into buffer bytes 2 onward. The copy length is min(capacity - offset, 0 if the offset is at or past capacity; count x 512; 510).
- R6: A write clears the media flag and copies buffer bytes 2 onward into the store from the byte offset, using the length rule of R5. Store bytes outside that range keep their values.
- R7: Every command ends with `done` high for exactly one cycle. A successful command leaves status = 0x00 and error = 0x00, with no ready bit.
- R8: After reset the media flag is 0, busy and done are 0, and status and error are 0x00. A `media_mark` pulse sets the flag one cycle later. When a mark and a flag-clearing write arrive in the same cycle, the mark wins.
- R9: While busy, a command strobe is ignored and host buffer writes are ignored.
- R10: A sector count of zero copies no bytes. A zero-count read still returns the zeroed buffer with its flag word.
- R11: Buffer byte 2k is the low byte of word k and byte 2k+1 is the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_feature | input | 8 | Sub-operation code |
| cmd_offset | input | 16 | Sector offset (high and low cylinder bytes) |
| cmd_count | input | 8 | Sector count |
| media_mark | input | 1 | Sets the media-changed flag |
| buf_addr | input | 8 | Host buffer word address |
| buf_we | input | 1 | Host buffer word write enable |
| buf_wdata | input | 16 | Host buffer write word |
| buf_rdata | output | 16 | Host buffer read word at buf_addr |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Status of the last command |
| error | output | 8 | Error code of the last command |
| media_flag | output | 1 | Media-changed flag |

## Verification
The bench sweeps all 256 feature codes. An engine that decodes the code loosely would accept an illegal code, or refuse a legal one, and report the wrong status. Reads and writes run with counts 0, 1 and 2 against a 32-byte store. An engine that clamps the length wrongly would spill store bytes past byte 33, drop bytes from the tail, or copy data on a zero count. Offsets just outside the store and at the far end of the range must abort with nothing changed. An engine that compared the wrong width, or let an aborted write clear the flag, would change the store or the flag. A second strobe and host writes issued during a busy read must leave no trace. An engine that accepted them would corrupt the buffer, clear the flag or produce a second done pulse.

// File: rtl/cf_meta_pkg.sv
package cf_meta_pkg;

   localparam logic [7:0] FEAT_INQUIRY = 8'h02;
   localparam logic [7:0] FEAT_READ    = 8'h03;
   localparam logic [7:0] FEAT_WRITE   = 8'h04;

   localparam logic [7:0] STATUS_ERR   = 8'h01;
   localparam logic [7:0] ERROR_ABORT  = 8'h04;

   localparam int SECT_SHIFT = 9;
   localparam int HDR_WORDS  = 7;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PREP,
      ST_COPY,
      ST_FIN
   } meta_state_t;

   typedef enum logic [1:0] {
      OP_INQ,
      OP_RD,
      OP_WR
   } meta_op_t;

endpackage

// File: rtl/cf_meta_buf.sv
module cf_meta_buf
   import cf_meta_pkg::*;
#(
   parameter int WORDS = 256,
   localparam int WA = $clog2(WORDS),
   localparam int BA = WA + 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld,
   input  logic [HDR_WORDS*16-1:0] hdr_vec,
   input  logic [BA-1:0]          bb_addr,
   input  logic                   bb_we,
   input  logic [7:0]             bb_wdata,
   output logic [7:0]             bb_rdata,
   input  logic [WA-1:0]          h_addr,
   input  logic                   h_we,
   input  logic [15:0]            h_wdata,
   output logic [15:0]            h_rdata
);

   logic [15:0] words [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [15:0] q;
      logic [15:0] ld_val;
      if (g < HDR_WORDS) begin : g_hdr
         assign ld_val = hdr_vec[g*16 +: 16];
      end else begin : g_plain
         assign ld_val = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (ld) begin
            q <= ld_val;
         end else if (bb_we && bb_addr[BA-1:1] == WA'(g)) begin
            if (bb_addr[0]) q[15:8] <= bb_wdata;
            else            q[7:0]  <= bb_wdata;
         end else if (h_we && h_addr == WA'(g)) begin
            q <= h_wdata;
         end
      end
      assign words[g] = q;
   end

   assign h_rdata  = words[h_addr];
   assign bb_rdata = bb_addr[0] ? words[bb_addr[BA-1:1]][15:8]
                                : words[bb_addr[BA-1:1]][7:0];

   // host port is gated off while the engine owns the buffer
   p_host_excluded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      h_we |-> !(ld || bb_we));

endmodule

// File: rtl/cf_meta_store.sv
module cf_meta_store #(
   parameter int CAP = 32,
   localparam int SAW = $clog2(CAP + 1)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [SAW-1:0] addr,
   input  logic           we,
   input  logic [7:0]     wdata,
   output logic [7:0]     rdata
);

   logic [7:0] cells [CAP];

   for (genvar g = 0; g < CAP; g++) begin : g_cell
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= '0;
         else if (we && addr == SAW'(g))    q <= wdata;
      end
      assign cells[g] = q;
   end

   assign rdata = (addr < SAW'(CAP)) ? cells[addr] : 8'h00;

   p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (addr < SAW'(CAP)));

endmodule

// File: rtl/cf_meta_ctrl.sv
module cf_meta_ctrl
   import cf_meta_pkg::*;
#(
   parameter int CAP      = 32,
   parameter int MAX_COPY = 510,
   parameter int OFS_W    = 16,
   parameter int CNT_W    = 8,
   parameter int BA       = 9,
   localparam int SAW = $clog2(CAP + 1),
   localparam int LW  = $clog2(MAX_COPY + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [7:0]              cmd_feature,
   input  logic [OFS_W-1:0]        cmd_offset,
   input  logic [CNT_W-1:0]        cmd_count,
   input  logic                    media_mark,
   output logic                    busy,
   output logic                    done,
   output logic                    err,
   output logic                    media_flag,
   output logic                    buf_ld,
   output logic [HDR_WORDS*16-1:0] hdr_vec,
   output logic [BA-1:0]           bb_addr,
   output logic                    bb_we,
   input  logic [7:0]              bb_rdata,
   output logic [7:0]              bb_wdata,
   output logic [SAW-1:0]          st_addr,
   output logic                    st_we,
   input  logic [7:0]              st_rdata,
   output logic [7:0]              st_wdata
);

   localparam logic [31:0] CAP32  = 32'(CAP);
   localparam logic [31:0] LIM32  = CAP32 + 32'd2;
   localparam logic [31:0] MAXC32 = 32'(MAX_COPY);
   localparam logic [31:0] SPD32  = ((CAP32 - 32'd1) >> SECT_SHIFT) + 32'd1;

   meta_state_t       state_q;
   meta_op_t          op_q, op_n;
   logic [SAW-1:0]    base_q;
   logic [LW-1:0]     len_q, idx_q;
   logic              err_q, flag_q;

   logic              feat_ok, range_bad, accept, abort_n, wr_ok;
   logic [31:0]       base32, cnt32, avail32, len32;

   always_comb begin
      feat_ok = 1'b1;
      op_n    = OP_INQ;
      case (cmd_feature)
         FEAT_INQUIRY: op_n = OP_INQ;
         FEAT_READ:    op_n = OP_RD;
         FEAT_WRITE:   op_n = OP_WR;
         default:      feat_ok = 1'b0;
      endcase
   end

   always_comb begin
      base32  = 32'(cmd_offset) << SECT_SHIFT;
      cnt32   = 32'(cmd_count) << SECT_SHIFT;
      avail32 = (base32 >= CAP32) ? 32'd0 : CAP32 - base32;
      len32   = avail32;
      if (cnt32 < len32)  len32 = cnt32;
      if (MAXC32 < len32) len32 = MAXC32;
   end

   assign range_bad = (op_n != OP_INQ) && (base32 > LIM32);
   assign accept    = cmd_valid && (state_q == ST_IDLE);
   assign abort_n   = !feat_ok || range_bad;
   assign wr_ok     = accept && !abort_n && (op_n == OP_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_INQ;
         base_q  <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               idx_q <= '0;
               if (abort_n) begin
                  err_q   <= 1'b1;
                  state_q <= ST_FIN;
               end else begin
                  err_q  <= 1'b0;
                  op_q   <= op_n;
                  base_q <= SAW'(base32);
                  len_q  <= LW'(len32);
                  if (op_n == OP_WR)
                     state_q <= (len32 == 32'd0) ? ST_FIN : ST_COPY;
                  else
                     state_q <= ST_PREP;
               end
            end
            ST_PREP: state_q <= (op_q == OP_RD && len_q != '0) ? ST_COPY : ST_FIN;
            ST_COPY: begin
               idx_q <= idx_q + LW'(1);
               if (idx_q == len_q - LW'(1)) state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (media_mark) flag_q <= 1'b1;
      else if (wr_ok)      flag_q <= 1'b0;
   end

   always_comb begin
      hdr_vec = '0;
      if (op_q == OP_INQ) begin
         hdr_vec[0*16 +: 16] = 16'h0001;
         hdr_vec[2*16 +: 16] = {15'd0, flag_q};
         hdr_vec[3*16 +: 16] = CAP32[15:0];
         hdr_vec[4*16 +: 16] = CAP32[31:16];
         hdr_vec[5*16 +: 16] = SPD32[15:0];
         hdr_vec[6*16 +: 16] = SPD32[31:16];
      end else begin
         hdr_vec[0*16 +: 16] = {15'd0, flag_q};
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_FIN);
   assign err        = err_q;
   assign media_flag = flag_q;
   assign buf_ld     = (state_q == ST_PREP);
   assign bb_addr    = BA'(idx_q) + BA'(2);
   assign st_addr    = base_q + SAW'(idx_q);
   assign bb_we      = (state_q == ST_COPY) && (op_q == OP_RD);
   assign st_we      = (state_q == ST_COPY) && (op_q == OP_WR);
   assign bb_wdata   = st_rdata;
   assign st_wdata   = bb_rdata;

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_mark_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      media_mark |=> media_flag);
   p_idle_via_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> $past(done));
   p_zero_len_no_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bb_we || st_we) |-> (len_q != '0));
   p_abort_no_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_q) |-> $past(state_q == ST_IDLE));

endmodule

// File: rtl/cf_meta_engine.sv
module cf_meta_engine
   import cf_meta_pkg::*;
#(
   parameter int CAP_BYTES = 32,
   parameter int BUF_BYTES = 512,
   parameter int OFS_W     = 16,
   parameter int CNT_W     = 8,
   localparam int BUF_WORDS = BUF_BYTES / 2,
   localparam int WA        = $clog2(BUF_WORDS),
   localparam int BA        = WA + 1,
   localparam int MAX_COPY  = BUF_BYTES - 2,
   localparam int SAW       = $clog2(CAP_BYTES + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_feature,
   input  logic [OFS_W-1:0] cmd_offset,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic             media_mark,
   input  logic [WA-1:0]    buf_addr,
   input  logic             buf_we,
   input  logic [15:0]      buf_wdata,
   output logic [15:0]      buf_rdata,
   output logic             busy,
   output logic             done,
   output logic [7:0]       status,
   output logic [7:0]       error,
   output logic             media_flag
);

   if (CAP_BYTES < 1 || CAP_BYTES > 4096) begin : g_bad_cap
      $error("CAP_BYTES out of supported range");
   end
   if (BUF_BYTES < 2 * HDR_WORDS || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two holding the header");
   end
   if (OFS_W + SECT_SHIFT > 32 || CNT_W + SECT_SHIFT > 32) begin : g_bad_w
      $error("offset or count too wide");
   end

   logic                    err, buf_ld, bb_we, st_we;
   logic [HDR_WORDS*16-1:0] hdr_vec;
   logic [BA-1:0]           bb_addr;
   logic [7:0]              bb_rdata, bb_wdata, st_rdata, st_wdata;
   logic [SAW-1:0]          st_addr;

   cf_meta_ctrl #(
      .CAP(CAP_BYTES), .MAX_COPY(MAX_COPY), .OFS_W(OFS_W), .CNT_W(CNT_W), .BA(BA)
   ) u_ctrl (
      .clk, .rst_n, .cmd_valid, .cmd_feature, .cmd_offset, .cmd_count,
      .media_mark, .busy, .done, .err, .media_flag, .buf_ld, .hdr_vec,
      .bb_addr, .bb_we, .bb_rdata, .bb_wdata, .st_addr, .st_we, .st_rdata,
      .st_wdata
   );

   cf_meta_buf #(.WORDS(BUF_WORDS)) u_buf (
      .clk, .rst_n, .ld(buf_ld), .hdr_vec, .bb_addr, .bb_we, .bb_wdata,
      .bb_rdata, .h_addr(buf_addr), .h_we(buf_we && !busy),
      .h_wdata(buf_wdata), .h_rdata(buf_rdata)
   );

   cf_meta_store #(.CAP(CAP_BYTES)) u_store (
      .clk, .rst_n, .addr(st_addr), .we(st_we), .wdata(st_wdata),
      .rdata(st_rdata)
   );

   assign status = err ? STATUS_ERR  : 8'h00;
   assign error  = err ? ERROR_ABORT : 8'h00;

   p_status_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((status == 8'h00) == (error == 8'h00)));

endmodule

// File: tb/cf_meta_engine_test.sv
`timescale 1ns/1ps
module cf_meta_engine_test;

   localparam int CAP = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_feature = '0;
   logic [15:0] cmd_offset = '0;
   logic [7:0]  cmd_count = '0;
   logic        media_mark = 1'b0;
   logic [7:0]  buf_addr = '0;
   logic        buf_we = 1'b0;
   logic [15:0] buf_wdata = '0;
   logic [15:0] buf_rdata;
   logic        busy, done, media_flag;
   logic [7:0]  status, error;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [7:0]  mstore [CAP];
   logic [15:0] bufm [256];
   bit          mflag;

   always #10 clk = ~clk;

   cf_meta_engine uut (
      .clk, .rst_n, .cmd_valid, .cmd_feature, .cmd_offset, .cmd_count,
      .media_mark, .buf_addr, .buf_we, .buf_wdata, .buf_rdata, .busy, .done,
      .status, .error, .media_flag
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input int b);
      return b[0] ? bufm[b >> 1][15:8] : bufm[b >> 1][7:0];
   endfunction

   task automatic set_mbyte(input int b, input logic [7:0] v);
      if (b[0]) bufm[b >> 1][15:8] = v;
      else      bufm[b >> 1][7:0]  = v;
   endtask

   // reference model of one command; returns whether it aborts
   task automatic model_cmd(input logic [7:0] f, input logic [15:0] off,
                            input logic [7:0] cnt, output bit ab);
      longint base = longint'(off) * 512;
      longint len;
      bit legal = (f == 8'h02) || (f == 8'h03) || (f == 8'h04);
      ab = !legal || (f != 8'h02 && base > CAP + 2);
      len = (base >= CAP) ? 0 : CAP - base;
      if (longint'(cnt) * 512 < len) len = longint'(cnt) * 512;
      if (len > 510) len = 510;
      if (ab) return;
      if (f == 8'h02) begin
         foreach (bufm[w]) bufm[w] = '0;
         bufm[0] = 16'h0001;
         bufm[2] = {15'd0, mflag};
         bufm[3] = 16'(CAP);
         bufm[5] = 16'(((CAP - 1) >> 9) + 1);
      end else if (f == 8'h03) begin
         foreach (bufm[w]) bufm[w] = '0;
         bufm[0] = {15'd0, mflag};
         for (int i = 0; i < len; i++) set_mbyte(2 + i, mstore[base + i]);
      end else begin
         mflag = 1'b0;
         for (int i = 0; i < len; i++) mstore[base + i] = mbyte(2 + i);
      end
   endtask

   task automatic wait_done(input string tag);
      int w = 0;
      while (!done && w < 2000) begin
         @(negedge clk);
         w++;
      end
      if (w >= 2000) chk({tag, " done never came"}, 0, 1);
   endtask

   task automatic run_cmd(input string tag, input logic [7:0] f,
                          input logic [15:0] off, input logic [7:0] cnt);
      bit ab;
      model_cmd(f, off, cnt, ab);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_feature = f; cmd_offset = off; cmd_count = cnt;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done(tag);
      chk({tag, " status"}, status, ab ? 8'h01 : 8'h00);
      chk({tag, " error"},  error,  ab ? 8'h04 : 8'h00);
      @(negedge clk);
      chk({tag, " R7 done one cycle"}, {busy, done}, 2'b00);
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      buf_we = 1'b1; buf_addr = a; buf_wdata = d;
      @(negedge clk);
      buf_we = 1'b0;
      bufm[a] = d;
   endtask

   task automatic cmp_buf(input string tag);
      for (int w = 0; w < 256; w++) begin
         buf_addr = 8'(w);
         #1;
         chk($sformatf("%s word %0d", tag, w), buf_rdata, bufm[w]);
      end
   endtask

   task automatic fill_buf(input int seed);
      for (int w = 0; w < 256; w++) host_wr(8'(w), 16'((w * 37 + seed) * 257 + w));
   endtask

   task automatic pulse_mark();
      @(negedge clk);
      media_mark = 1'b1;
      @(negedge clk);
      media_mark = 1'b0;
      mflag = 1'b1;
      chk("R8 mark sets flag", media_flag, 1'b1);
   endtask

   initial begin
      foreach (mstore[i]) mstore[i] = '0;
      foreach (bufm[i]) bufm[i] = '0;
      mflag = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset busy/done", {busy, done}, 2'b00);
      chk("R8 reset status", status, 8'h00);
      chk("R8 reset error", error, 8'h00);
      chk("R8 reset flag", media_flag, 1'b0);

      // R2 R3 inquiry, flag clear then set
      run_cmd("R2 inquiry", 8'h02, 16'h0, 8'h0);
      cmp_buf("R2 R3 inquiry flag0");
      pulse_mark();
      run_cmd("R2 inquiry", 8'h02, 16'h0, 8'h3);
      cmp_buf("R2 inquiry flag1");

      // R6 write one sector then R5 R11 read back
      fill_buf(11);
      run_cmd("R6 write cnt1", 8'h04, 16'h0, 8'h1);
      chk("R6 write clears flag", media_flag, 1'b0);
      run_cmd("R5 read cnt1", 8'h03, 16'h0, 8'h1);
      cmp_buf("R5 R11 read cnt1");

      // R10 zero count write leaves store; zero count read
      fill_buf(99);
      pulse_mark();
      run_cmd("R10 write cnt0", 8'h04, 16'h0, 8'h0);
      chk("R10 write cnt0 clears flag", media_flag, 1'b0);
      run_cmd("R10 read cnt0", 8'h03, 16'h0, 8'h0);
      cmp_buf("R10 read cnt0");
      run_cmd("R10 read back", 8'h03, 16'h0, 8'h1);
      cmp_buf("R10 store kept");

      // R5 R6 count 2, clamp to capacity
      fill_buf(5);
      run_cmd("R6 write cnt2", 8'h04, 16'h0, 8'h2);
      run_cmd("R5 read cnt2", 8'h03, 16'h0, 8'h2);
      cmp_buf("R5 clamp cnt2");

      // R4 out-of-range offsets abort with nothing changed
      pulse_mark();
      fill_buf(200);
      run_cmd("R4 write off1", 8'h04, 16'h1, 8'h1);
      chk("R4 flag kept", media_flag, 1'b1);
      run_cmd("R4 write offmax", 8'h04, 16'hFFFF, 8'hFF);
      run_cmd("R4 read off1", 8'h03, 16'h1, 8'h1);
      cmp_buf("R4 buffer kept");
      run_cmd("R4 read offmax", 8'h03, 16'hFFFF, 8'h1);
      run_cmd("R4 read back", 8'h03, 16'h0, 8'h1);
      cmp_buf("R4 store kept");

      // R9 strobe and host writes while busy are ignored
      begin
         bit ab;
         model_cmd(8'h03, 16'h0, 8'h1, ab);
         @(negedge clk);
         cmd_valid = 1'b1; cmd_feature = 8'h03; cmd_offset = '0; cmd_count = 8'h1;
         @(negedge clk);
         cmd_feature = 8'h04;
         buf_we = 1'b1; buf_addr = 8'd200; buf_wdata = 16'hBEEF;
         chk("R9 busy during read", busy, 1'b1);
         @(negedge clk);
         cmd_valid = 1'b0;
         while (busy) @(negedge clk);
         buf_we = 1'b0;
         chk("R9 status", status, 8'h00);
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9 no second command", {busy, done}, 2'b00);
         end
         chk("R9 flag untouched", media_flag, 1'b1);
         cmp_buf("R9 host write ignored");
      end

      // R8 mark wins over a clearing write in the same cycle
      begin
         @(negedge clk);
         cmd_valid = 1'b1; cmd_feature = 8'h04; cmd_offset = '0; cmd_count = 8'h0;
         media_mark = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0; media_mark = 1'b0;
         wait_done("R8 race");
         chk("R8 mark beats write", media_flag, 1'b1);
         mflag = 1'b1;
         @(negedge clk);
      end

      // R1 sweep of every feature code
      for (int f = 0; f < 256; f++)
         run_cmd($sformatf("R1 feature %02h", f), 8'(f), 16'h0, 8'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule